// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches a word from a small internal instruction array and decodes it. It reads two registers, runs the ALU and, where the instruction needs it, writes the register file or a small internal data array, all before the next rising edge. Seven instructions are supported: add, subtract, or-immediate, load word, store word, branch-if-equal and jump. R-type and, or and set-on-less-than also work, because the ALU decoder handles them.

Control is built in two levels. The opcode decoder sets the datapath selects and passes a 3-bit ALU-op code to a local ALU decoder. The ALU decoder combines that code with the low bits of the function field and produces the 3-bit ALU control. The instruction array is filled through a load port while reset is held. The core's register and memory write activity is visible on plain output pins, so the surrounding logic can observe results. There is no streaming data interface and therefore no valid/ready handshake.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the PC is 0, no register or data-memory write is reported, and a high `ld_en` writes `ld_data` into instruction word `ld_idx` at the rising edge.
- R2: When an instruction is neither a taken branch nor a jump, the next PC is PC+4.
- R3: R-type (opcode 000000) writes the register in bits [15:11]. Function code 100000 adds, 100010 subtracts, 100100 ands, 100101 ors and 101010 gives 1 when rs < rt as signed values, else 0. These use ALU controls 010, 110, 000, 001 and 111.
- R4: Or-immediate (opcode 001101) writes rs OR the zero-extended bits [15:0] into the register in bits [20:16].
- R5: Store (opcode 101011) writes rt to data address rs + sign-extended imm16 and does not write the register file. Load (opcode 100011) writes the word held at that address into rt.
- R6: Branch-if-equal (opcode 000100) goes to PC+4+(sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise.
- R7: Jump (opcode 000010) goes to {PC+4[31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads as zero, and a write to it is discarded.
- R9: Branch and jump write neither the register file nor the data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Instruction-array write enable, honoured only in reset |
| ld_idx | input | 8 | Instruction word index to write |
| ld_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write taking place this cycle |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value being written to the register file |
| dm_we_o | output | 1 | Data-memory write taking place this cycle |
| dm_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data being stored |

## Verification
The hardest case to reach from the ports is a load that has to return a word an earlier store placed in the data array. The array cannot be seen directly, so the bench stores a computed sum and loads it into another register. A taken branch then compares the two registers, and because the branch is only taken if they are equal, the round trip through memory is shown. A discarded write to register 0 is shown in the same way: the next instruction adds r0 to itself and must report zero.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [2:0] AOP_RTYPE = 3'b100;
  localparam logic [2:0] AOP_OR    = 3'b010;
  localparam logic [2:0] AOP_ADD   = 3'b000;
  localparam logic [2:0] AOP_SUB   = 3'b001;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       reg_wr;
    logic       mem_wr;
    logic       branch;
    logic       jump;
    logic       sign_ext;
    logic [2:0] aop;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    unique case (opcode)
      OPC_RTYPE: begin ctl.dst_rd = 1'b1; ctl.reg_wr = 1'b1; ctl.aop = AOP_RTYPE; end
      OPC_ORI:   begin ctl.src_imm = 1'b1; ctl.reg_wr = 1'b1; ctl.aop = AOP_OR; end
      OPC_LOAD:  begin
        ctl.src_imm = 1'b1; ctl.wb_mem = 1'b1; ctl.reg_wr = 1'b1;
        ctl.sign_ext = 1'b1; ctl.aop = AOP_ADD;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1; ctl.mem_wr = 1'b1; ctl.sign_ext = 1'b1; ctl.aop = AOP_ADD;
      end
      OPC_BEQ:   begin ctl.branch = 1'b1; ctl.sign_ext = 1'b1; ctl.aop = AOP_SUB; end
      OPC_JUMP:  ctl.jump = 1'b1;
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec (
  input  logic [2:0] aop,
  input  logic [3:0] fn,
  output logic [2:0] alu_ctl
);
  always_comb begin
    alu_ctl[2] = (~aop[2] & aop[0]) | (aop[2] & ~fn[2] & fn[1] & ~fn[0]);
    alu_ctl[1] = (~aop[2] & ~aop[1]) | (aop[2] & ~fn[2] & ~fn[0]);
    alu_ctl[0] = (~aop[2] & aop[1])
               | (aop[2] & ~fn[3] & fn[2] & ~fn[1] & fn[0])
               | (aop[2] & fn[3] & ~fn[2] & fn[1] & ~fn[0]);
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   ctl,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [1:NREGS-1];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |-> (rd1 == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W      = 32,
  parameter int IWORDS = 256,
  parameter int DWORDS = 256,
  localparam int IAW   = $clog2(IWORDS),
  localparam int DAW   = $clog2(DWORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic [IAW-1:0] ld_idx,
  input  logic [W-1:0]   ld_data,
  output logic [W-1:0]   pc_o,
  output logic           rf_we_o,
  output logic [4:0]     rf_waddr_o,
  output logic [W-1:0]   rf_wdata_o,
  output logic           dm_we_o,
  output logic [W-1:0]   dm_addr_o,
  output logic [W-1:0]   dm_wdata_o
);
  logic [W-1:0] pc;
  logic [W-1:0] imem [IWORDS];
  logic [W-1:0] dmem [DWORDS];
  logic [W-1:0] inst;
  ctrl_t        ctl;
  logic [2:0]   alu_ctl;
  logic [W-1:0] rs_val, rt_val, ext_imm, alu_b, alu_y, ld_word;
  logic         alu_zero, take_br;
  logic [W-1:0] pc4, pc_nxt;

  assign inst = imem[pc[IAW+1:2]];

  sc_main_dec u_mdec (.opcode(inst[31:26]), .ctl(ctl));
  sc_alu_dec  u_adec (.aop(ctl.aop), .fn(inst[3:0]), .alu_ctl(alu_ctl));

  sc_regfile #(.W(W), .NREGS(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(inst[25:21]), .ra2(inst[20:16]), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we_o), .wa(rf_waddr_o), .wd(rf_wdata_o)
  );

  assign ext_imm = ctl.sign_ext ? {{(W-16){inst[15]}}, inst[15:0]}
                                : {{(W-16){1'b0}}, inst[15:0]};
  assign alu_b   = ctl.src_imm ? ext_imm : rt_val;

  sc_alu #(.W(W)) u_alu (.a(rs_val), .b(alu_b), .ctl(alu_ctl), .y(alu_y), .zero(alu_zero));

  assign ld_word = dmem[alu_y[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (dm_we_o) dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en) imem[ld_idx] <= ld_data;
  end

  assign take_br = ctl.branch & alu_zero;
  assign pc4     = pc + W'(4);
  always_comb begin
    if (ctl.jump)    pc_nxt = {pc4[W-1:28], inst[25:0], 2'b00};
    else if (take_br) pc_nxt = pc4 + {ext_imm[W-3:0], 2'b00};
    else             pc_nxt = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign pc_o       = pc;
  assign rf_we_o    = ctl.reg_wr & ~rst;
  assign rf_waddr_o = ctl.dst_rd ? inst[15:11] : inst[20:16];
  assign rf_wdata_o = ctl.wb_mem ? ld_word : alu_y;
  assign dm_we_o    = ctl.mem_wr & ~rst;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !take_br) |=> (pc == $past(pc) + W'(4)));
  // R6
  br_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc == $past(pc) + W'(4) + {$past(inst[W-19:0]) , 2'b00} - W'(0)
                   || pc == $past(pc) + W'(4) + ({{(W-16){$past(inst[15])}}, $past(inst[15:0])} << 2)));
  // R9
  no_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch || ctl.jump) |-> (!rf_we_o && !dm_we_o));
  // R5
  st_imm_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (ctl.src_imm && !rf_we_o));
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // check the current instruction's effects, then advance one cycle
  task automatic step(string tag, logic [31:0] pc, logic rwe, int ra, logic [31:0] rd,
                      logic mwe, logic [31:0] ma, logic [31:0] md);
    #1;
    chk({tag, " pc"}, pc_o, pc);
    chk({tag, " rf_we"}, 32'(rf_we_o), 32'(rwe));
    if (rwe) begin
      chk({tag, " rf_waddr"}, 32'(rf_waddr_o), 32'(ra));
      chk({tag, " rf_wdata"}, rf_wdata_o, rd);
    end
    chk({tag, " dm_we"}, 32'(dm_we_o), 32'(mwe));
    if (mwe) begin
      chk({tag, " dm_addr"}, dm_addr_o, ma);
      chk({tag, " dm_wdata"}, dm_wdata_o, md);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load_word(int idx, logic [31:0] w);
    ld_en = 1'b1; ld_idx = 8'(idx); ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // R1: program load during reset, reset state
  task automatic t_reset;
    for (int i = 0; i < 24; i++) load_word(i, enc_i(6'b001101, 0, 11, 16'h0BAD));
    load_word(0,  enc_i(6'b001101, 0, 1, 16'h00F0));
    load_word(1,  enc_i(6'b001101, 0, 2, 16'h8001));
    load_word(2,  enc_r(1, 2, 3, 6'b100000));
    load_word(3,  enc_r(1, 2, 4, 6'b100010));
    load_word(4,  enc_i(6'b101011, 0, 3, 16'h0008));
    load_word(5,  enc_i(6'b100011, 0, 5, 16'h0008));
    load_word(6,  enc_i(6'b101011, 1, 2, 16'hFFFC));
    load_word(7,  enc_r(1, 1, 0, 6'b100000));
    load_word(8,  enc_r(0, 0, 6, 6'b100000));
    load_word(9,  enc_i(6'b000100, 1, 2, 16'h0005));
    load_word(10, enc_i(6'b000100, 3, 5, 16'h0002));
    load_word(13, {6'b000010, 26'd20});
    load_word(20, enc_r(1, 2, 8, 6'b100100));
    load_word(21, enc_r(1, 2, 9, 6'b100101));
    load_word(22, enc_r(4, 1, 10, 6'b101010));
    load_word(23, enc_i(6'b000100, 0, 0, 16'hFFFF));
    #1;
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset rf_we", 32'(rf_we_o), 32'h0);
    chk("R1 reset dm_we", 32'(dm_we_o), 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_ori;
    step("R4 ori zero", 32'h00, 1, 1, 32'h0000_00F0, 0, 0, 0);
    step("R4 ori noext", 32'h04, 1, 2, 32'h0000_8001, 0, 0, 0);
  endtask

  task automatic t_rtype;
    step("R3 add", 32'h08, 1, 3, 32'h0000_80F1, 0, 0, 0);
    step("R3 sub", 32'h0C, 1, 4, 32'hFFFF_80EF, 0, 0, 0);
  endtask

  task automatic t_mem;
    step("R5 store", 32'h10, 0, 0, 0, 1, 32'h8, 32'h0000_80F1);
    step("R5 load", 32'h14, 1, 5, 32'h0000_80F1, 0, 0, 0);
    step("R5 store negoff", 32'h18, 0, 0, 0, 1, 32'hEC, 32'h0000_8001);
  endtask

  task automatic t_r0;
    step("R8 write r0", 32'h1C, 1, 0, 32'h0000_01E0, 0, 0, 0);
    step("R8 read r0", 32'h20, 1, 6, 32'h0, 0, 0, 0);
  endtask

  task automatic t_branch;
    step("R6 R9 beq not taken", 32'h24, 0, 0, 0, 0, 0, 0);
    step("R6 R9 beq taken", 32'h28, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_jump;
    step("R7 R9 jump", 32'h34, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_funct;
    step("R3 and", 32'h50, 1, 8, 32'h0, 0, 0, 0);
    step("R3 or", 32'h54, 1, 9, 32'h0000_80F1, 0, 0, 0);
    step("R3 slt", 32'h58, 1, 10, 32'h1, 0, 0, 0);
  endtask

  task automatic t_loop;
    step("R6 beq back", 32'h5C, 0, 0, 0, 0, 0, 0);
    step("R6 R2 beq back again", 32'h5C, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ori();
    t_rtype();
    t_mem();
    t_r0();
    t_branch();
    t_jump();
    t_funct();
    t_loop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule